// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside the data side of a private cache and watches operations as they complete. It holds one lock reservation, made of a line address and the ID of the requester that made it. A load-linked completion sets the reservation. A store-conditional completion is checked against it and reports a one-bit result. Other write-class completions may release it. When a locked read-modify-write sequence runs, the block also produces strobes that stall the cache controller's request queue for the line and later release it.

A completion is presented for one cycle on `done_valid_i` with its operation code, line address, requester ID and a tag-present flag. One cycle later the block reports `rsp_valid_o`, the success bit `rsp_ok_o`, and any block or unblock strobe together with its line. The `test_mode_i` input bypasses all reservation handling. The `inval_valid_i`/`inval_line_i` pair stands in for coherence-driven loss of a reservation.

Top module: `resv_monitor`

## Requirements
- R1: After every cycle with `done_valid_i` high, `rsp_valid_o` is high in the next cycle, and it is low in every other cycle. `rsp_ok_o` is 1 for success and 0 for failure.
- R2: A load-linked (op code 6) always reports success. It sets the reservation to its line and requester ID and replaces any earlier reservation.
- R3: A store-conditional (op code 7) reports 1 only if a reservation is held with the same line and the same requester ID. Otherwise it reports 0.
- R4: A store-conditional clears a reservation held on its line, whatever its outcome and whatever its requester ID.
- R5: Any other write-class completion (op codes 2 store, 3 atomic, 4 rmw-read, 5 rmw-write, 8 locked-rmw-read, 9 locked-rmw-write, 10 flush) reports success. It clears the reservation only when `tag_hit_i` is high and the reservation matches both its line and its requester ID.
- R6: Read completions (op codes 0 load, 1 instruction fetch) and the unused codes 11 to 15 report success and leave the reservation unchanged.
- R7: A locked-rmw-read completion (code 8) pulses `block_o` for one cycle, and a locked-rmw-write completion (code 9) pulses `unblock_o` for one cycle. In both cases `hold_line_o` carries the operation's line. These strobes are produced in test mode as well.
- R8: While `test_mode_i` is high, every completion reports success and the reservation is neither set nor cleared.
- R9: When `inval_valid_i` is high and `inval_line_i` matches the reserved line, the reservation is cleared. In the same cycle this clear beats a load-linked to that line, and it makes a store-conditional to that line fail.
- R10: Reset leaves no reservation and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| done_valid_i | input | 1 | A completion is presented this cycle |
| done_op_i | input | 4 | Operation code of the completion |
| done_line_i | input | LINE_W | Line address of the completion |
| done_id_i | input | ID_W | Requester ID of the completion |
| tag_hit_i | input | 1 | The line's tag is present in the cache |
| test_mode_i | input | 1 | Bypass reservation handling |
| inval_valid_i | input | 1 | Invalidate the reservation on a line |
| inval_line_i | input | LINE_W | Line address to invalidate |
| rsp_valid_o | output | 1 | Result of last cycle's completion is valid |
| rsp_ok_o | output | 1 | Success (1) or failure (0) |
| block_o | output | 1 | Stall the request queue for `hold_line_o` |
| unblock_o | output | 1 | Release the request queue for `hold_line_o` |
| hold_line_o | output | LINE_W | Line that the block or unblock strobe refers to |

## Verification
An invalidate can fall in the same cycle as a load-linked or a store-conditional on the same line. The bench provokes this by driving `inval_valid_i` in the same cycle as the completion. For a load-linked, it then judges the outcome with a following store-conditional probe, which must fail. For a store-conditional, it reads the result directly from `rsp_ok_o`, which must be 0. The bench also sweeps every op code against matching and mismatching line, ID and tag-present inputs. In each case it infers whether the reservation survived from the result of a later store-conditional.

// File: rtl/resv_pkg.sv
package resv_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD     = 4'd0,
    OP_IFETCH   = 4'd1,
    OP_STORE    = 4'd2,
    OP_ATOMIC   = 4'd3,
    OP_RMW_RD   = 4'd4,
    OP_RMW_WR   = 4'd5,
    OP_LL       = 4'd6,
    OP_SC       = 4'd7,
    OP_LRMW_RD  = 4'd8,
    OP_LRMW_WR  = 4'd9,
    OP_FLUSH    = 4'd10
  } op_e;

  typedef struct packed {
    logic is_ll;
    logic is_sc;
    logic is_wr;   // write class other than sc
    logic is_lrd;
    logic is_lwr;
  } op_class_t;
endpackage

// File: rtl/resv_decode.sv
module resv_decode
  import resv_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output op_class_t       cls_o
);
  always_comb begin
    cls_o = '0;
    case (op_i)
      OP_LL:      cls_o.is_ll = 1'b1;
      OP_SC:      cls_o.is_sc = 1'b1;
      OP_STORE, OP_ATOMIC, OP_RMW_RD, OP_RMW_WR, OP_FLUSH:
                  cls_o.is_wr = 1'b1;
      OP_LRMW_RD: begin cls_o.is_wr = 1'b1; cls_o.is_lrd = 1'b1; end
      OP_LRMW_WR: begin cls_o.is_wr = 1'b1; cls_o.is_lwr = 1'b1; end
      default:    cls_o = '0;
    endcase
  end
endmodule

// File: rtl/resv_store.sv
module resv_store
  import resv_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  op_class_t         cls_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              tag_hit_i,
  input  logic              inv_v_i,
  input  logic [LINE_W-1:0] inv_line_i,
  output logic              own_o
);
  logic              r_v, n_v;
  logic [LINE_W-1:0] r_line, n_line;
  logic [ID_W-1:0]   r_id, n_id;
  logic              eff_v, line_eq;

  // invalidate wins over anything else this cycle
  assign eff_v   = r_v && !(inv_v_i && inv_line_i == r_line);
  assign line_eq = eff_v && (r_line == line_i);
  assign own_o   = line_eq && (r_id == id_i);

  always_comb begin
    n_v    = eff_v;
    n_line = r_line;
    n_id   = r_id;
    if (act_i) begin
      if (cls_i.is_ll) begin
        n_v    = !(inv_v_i && inv_line_i == line_i);
        n_line = line_i;
        n_id   = id_i;
      end else if (cls_i.is_sc) begin
        if (line_eq) n_v = 1'b0;
      end else if (cls_i.is_wr) begin
        if (tag_hit_i && own_o) n_v = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_v    <= 1'b0;
      r_line <= '0;
      r_id   <= '0;
    end else begin
      r_v    <= n_v;
      r_line <= n_line;
      r_id   <= n_id;
    end
  end
endmodule

// File: rtl/resv_hold.sv
module resv_hold
  import resv_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  op_class_t         cls_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              block_o,
  output logic              unblock_o,
  output logic [LINE_W-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_o   <= 1'b0;
      unblock_o <= 1'b0;
      line_o    <= '0;
    end else begin
      block_o   <= valid_i && cls_i.is_lrd;
      unblock_o <= valid_i && cls_i.is_lwr;
      if (valid_i && (cls_i.is_lrd || cls_i.is_lwr)) line_o <= line_i;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_valid_i,
  input  logic [3:0]        done_op_i,
  input  logic [LINE_W-1:0] done_line_i,
  input  logic [ID_W-1:0]   done_id_i,
  input  logic              tag_hit_i,
  input  logic              test_mode_i,
  input  logic              inval_valid_i,
  input  logic [LINE_W-1:0] inval_line_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              block_o,
  output logic              unblock_o,
  output logic [LINE_W-1:0] hold_line_o
);
  op_class_t cls;
  logic      own;

  resv_decode u_dec (.op_i(done_op_i), .cls_o(cls));

  resv_store #(.LINE_W(LINE_W), .ID_W(ID_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .act_i(done_valid_i && !test_mode_i), .cls_i(cls),
    .line_i(done_line_i), .id_i(done_id_i), .tag_hit_i(tag_hit_i),
    .inv_v_i(inval_valid_i), .inv_line_i(inval_line_i), .own_o(own)
  );

  resv_hold #(.LINE_W(LINE_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(done_valid_i), .cls_i(cls),
    .line_i(done_line_i), .block_o(block_o), .unblock_o(unblock_o),
    .line_o(hold_line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
    end else begin
      rsp_valid_o <= done_valid_i;
      rsp_ok_o    <= done_valid_i && (test_mode_i || !cls.is_sc || own);
    end
  end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int LINE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_valid_i,
  input logic [3:0]        done_op_i,
  input logic [LINE_W-1:0] done_line_i,
  input logic              test_mode_i,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              block_o,
  input logic              unblock_o,
  input logic [LINE_W-1:0] hold_line_o
);
  a_r1_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_i |=> rsp_valid_o);
  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_valid_i |=> !rsp_valid_o);
  a_r1_ok_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok_o |-> rsp_valid_o);
  a_r6_read_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && done_op_i <= 4'd1) |=> rsp_ok_o);
  a_r2_ll_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && done_op_i == 4'd6) |=> rsp_ok_o);
  a_r8_test_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && test_mode_i) |=> rsp_ok_o);
  a_r7_block_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && done_op_i == 4'd8) |=> (block_o && hold_line_o == $past(done_line_i)));
  a_r7_unblock_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && done_op_i == 4'd9) |=> (unblock_o && hold_line_o == $past(done_line_i)));
  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({block_o, unblock_o}));
  a_r7_block_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_valid_i && done_op_i == 4'd8) |=> !block_o);
endmodule

bind resv_monitor resv_monitor_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_valid_i(done_valid_i),
  .done_op_i(done_op_i), .done_line_i(done_line_i), .test_mode_i(test_mode_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o), .block_o(block_o),
  .unblock_o(unblock_o), .hold_line_o(hold_line_o)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int IW = 2;
  localparam logic [LW-1:0] LA = 8'h3C;
  localparam logic [LW-1:0] LB = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dv = 1'b0, tag = 1'b0, tm = 1'b0, iv = 1'b0;
  logic [3:0] op = '0;
  logic [LW-1:0] line = '0, il = '0;
  logic [IW-1:0] id = '0;
  logic rsp_valid, rsp_ok, blk, ubk;
  logic [LW-1:0] hline;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor #(.LINE_W(LW), .ID_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .done_valid_i(dv), .done_op_i(op),
    .done_line_i(line), .done_id_i(id), .tag_hit_i(tag), .test_mode_i(tm),
    .inval_valid_i(iv), .inval_line_i(il), .rsp_valid_o(rsp_valid),
    .rsp_ok_o(rsp_ok), .block_o(blk), .unblock_o(ubk), .hold_line_o(hline)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,ok,block,unblock} got %b expected %b", req, act, exp);
    end
  endtask

  task automatic run(input string req, input int o, input logic [LW-1:0] l,
                     input logic [IW-1:0] i, input logic t, input logic m,
                     input logic inv, input logic [LW-1:0] invl, input logic exp_ok);
    logic eb, eu;
    @(negedge clk);
    dv = 1'b1; op = 4'(o); line = l; id = i; tag = t; tm = m; iv = inv; il = invl;
    @(posedge clk);
    @(negedge clk);
    dv = 1'b0; iv = 1'b0; tm = 1'b0;
    eb = (o == 8);
    eu = (o == 9);
    check(req, {rsp_valid, rsp_ok, blk, ubk}, {1'b1, exp_ok, eb, eu});
    if (eb || eu) begin
      n_chk++;
      if (hline !== l) begin
        n_bad++;
        $display("FAIL R7: hold_line got %h expected %h", hline, l);
      end
    end
  endtask

  function automatic bit is_wr(int o);
    return (o >= 2 && o <= 5) || (o >= 8 && o <= 10);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {rsp_valid, rsp_ok, blk, ubk}, 4'b0000);
    rst_n = 1'b1;
    run("R10", 7, LA, 2'd1, 1'b1, 1'b0, 1'b0, '0, 1'b0);

    // sweep: op x line match x id match x tag present
    for (int o = 0; o < 16; o++)
      for (int lm = 0; lm < 2; lm++)
        for (int im = 0; im < 2; im++)
          for (int t = 0; t < 2; t++) begin
            logic [LW-1:0] l;
            logic [IW-1:0] i;
            logic eo, surv;
            l = lm ? LA : LB;
            i = im ? 2'd1 : 2'd2;
            run("R2", 6, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
            eo = (o == 7) ? (lm && im) : 1'b1;
            run(o == 7 ? "R3" : (is_wr(o) ? "R5" : "R6"), o, l, i, t[0],
                1'b0, 1'b0, '0, eo);
            if (o == 6)      surv = lm && im;
            else if (o == 7) surv = !lm;
            else if (is_wr(o)) surv = !(t && lm && im);
            else             surv = 1'b1;
            run(o == 6 ? "R2" : (o == 7 ? "R4" : (is_wr(o) ? "R5" : "R6")),
                7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, surv);
            run("R4", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
          end

    // test mode bypass
    run("R8", 7, LA, 2'd1, 1'b0, 1'b1, 1'b0, '0, 1'b1);
    run("R8", 6, LA, 2'd1, 1'b0, 1'b1, 1'b0, '0, 1'b1);
    run("R8", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    run("R8", 6, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R8", 7, LA, 2'd1, 1'b0, 1'b1, 1'b0, '0, 1'b1);
    run("R8", 2, LA, 2'd1, 1'b1, 1'b1, 1'b0, '0, 1'b1);
    run("R7", 8, LB, 2'd3, 1'b0, 1'b1, 1'b0, '0, 1'b1);
    run("R7", 9, LB, 2'd3, 1'b0, 1'b1, 1'b0, '0, 1'b1);
    run("R8", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);

    // invalidate interplay
    run("R9", 6, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R9", 0, LB, 2'd0, 1'b0, 1'b0, 1'b1, LA, 1'b1);
    run("R9", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    run("R9", 6, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R9", 0, LB, 2'd0, 1'b0, 1'b0, 1'b1, LB, 1'b1);
    run("R9", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R9", 6, LA, 2'd1, 1'b0, 1'b0, 1'b1, LA, 1'b1);
    run("R9", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    run("R9", 6, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R9", 7, LA, 2'd1, 1'b0, 1'b0, 1'b1, LA, 1'b0);
    run("R2", 6, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R2", 6, LB, 2'd2, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    run("R2", 7, LA, 2'd1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    run("R2", 7, LB, 2'd2, 1'b0, 1'b0, 1'b0, '0, 1'b1);

    @(negedge clk);
    check("R1", {rsp_valid, rsp_ok, blk, ubk}, 4'b0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule